// File: doc/BRIEF.md
# Secondary Bus Parity Error Tracker

This block sits inside a bus bridge and follows parity trouble on the downstream (secondary) bus. Each cycle it takes in event flags from the bus logic: a data parity error, a sampled PERR# line, an address/command parity error, the direction of the current cycle, and whether the bridge is the bus master. It holds three sticky status bits that software clears by writing ones. It also produces a one-cycle internal system-error (SERR) pulse when the enabled error responses call for one.

Two more controls come out of it. A combinational `no_claim` stops the bridge from accepting any cycle whose address phase carried bad parity, whatever the enables are. A registered `force_bad_par` tells the data path to corrupt parity on every outgoing downstream data phase of a transaction that arrived from upstream with bad parity. It lets go when that transaction ends.

All inputs and outputs are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `sbus_parity_tracker`

## Requirements
- R1: After reset, `status` is 3'b000 and `serr_pulse`, `force_bad_par` are 0.
- R2: `status[1]` (detected parity error) is set at the clock edge after any of these: `evt_data_perr`, `evt_addr_perr`, or `perr_seen` while `is_master` and `cyc_write` are both high.
- R3: `status[2]` (master data parity error) is set at the next edge when `is_master` and `en_perr_resp` are high and either (`perr_seen` and `cyc_write`) or (`evt_data_perr` and not `cyc_write`) holds.
- R4: `status[0]` (signalled system error) is set at the next edge when `evt_addr_perr` is high and `en_serr`, `en_perr_resp` and `en_bctrl_serr` are all high. It is not set if any one of those enables is low.
- R5: `serr_pulse` is high for exactly the one cycle after a cycle in which the R3 or R4 condition holds, and low after every other cycle.
- R6: `no_claim` equals `evt_addr_perr` in the same cycle, whatever the enables are.
- R7: `force_bad_par` goes high at the edge after `up_bad_par` is seen and stays high until the edge after `txn_end`. When `txn_end` and `up_bad_par` are high in the same cycle, `txn_end` wins.
- R8: With `w1c_strobe` high, each `w1c_mask` bit that is 1 clears the matching status bit, and bits that are 0 leave it unchanged. A set condition in the same cycle wins over the clear.
- R9: With no clear, a status bit that is set stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_data_perr | input | 1 | Data parity error detected on the secondary bus |
| perr_seen | input | 1 | PERR# sampled asserted |
| cyc_write | input | 1 | Current cycle is a write (1) or a read (0) |
| is_master | input | 1 | Bridge is master of the current cycle |
| evt_addr_perr | input | 1 | Address/command parity error detected |
| up_bad_par | input | 1 | Bad parity received from upstream for the current transaction |
| txn_end | input | 1 | Current downstream transaction finishes this cycle |
| en_serr | input | 1 | Command-register SERR enable |
| en_perr_resp | input | 1 | Bridge-control parity error response enable |
| en_bctrl_serr | input | 1 | Bridge-control SERR forwarding enable |
| w1c_strobe | input | 1 | Status write strobe |
| w1c_mask | input | 3 | Write-one-to-clear mask, bit order as `status` |
| status | output | 3 | {master data parity, detected parity, signalled system error} |
| serr_pulse | output | 1 | One-cycle internal system error |
| no_claim | output | 1 | Refuse to claim the current cycle |
| force_bad_par | output | 1 | Corrupt parity on outgoing downstream data |

## Verification
The bench drives each of the three enables low on its own during an address parity error. A design that ANDed too few of them would raise signalled-system-error and an SERR pulse. It makes PERR# arrive during a master read and a data parity error arrive during a master write. A design that mixed up the direction terms would flag a master data parity error there. It clears a bit in the same cycle a new error sets it; a design where the clear wins would drop a real error. It also ends a transaction in the cycle that upstream bad parity arrives, and a design that missed this would hold forced bad parity into the next transaction.

// File: rtl/sbpt_pkg.sv
package sbpt_pkg;
  localparam int unsigned STAT_W  = 3;
  localparam int unsigned ST_SSE  = 0;  // signalled system error
  localparam int unsigned ST_DPE  = 1;  // detected parity error
  localparam int unsigned ST_MDPE = 2;  // master data parity error

  typedef struct packed {
    logic mdpe;
    logic dpe;
    logic sse;
  } stat_set_t;
endpackage

// File: rtl/sbpt_event_qual.sv
module sbpt_event_qual
  import sbpt_pkg::*;
(
  input  logic      evt_data_perr,
  input  logic      perr_seen,
  input  logic      cyc_write,
  input  logic      is_master,
  input  logic      evt_addr_perr,
  input  logic      en_serr,
  input  logic      en_perr_resp,
  input  logic      en_bctrl_serr,
  output stat_set_t set_o,
  output logic      serr_req
);
  logic wr_perr, rd_perr;

  always_comb begin
    wr_perr    = perr_seen & cyc_write;
    rd_perr    = evt_data_perr & ~cyc_write;
    set_o.dpe  = evt_data_perr | evt_addr_perr | (wr_perr & is_master);
    set_o.mdpe = is_master & en_perr_resp & (wr_perr | rd_perr);
    set_o.sse  = evt_addr_perr & en_serr & en_perr_resp & en_bctrl_serr;
    serr_req   = set_o.mdpe | set_o.sse;
  end
endmodule

// File: rtl/sbpt_sticky_bit.sv
module sbpt_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R9: a set bit survives any cycle without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q) && !$past(clr_i)) |-> q);

  // R8: a clear without a coincident set empties the bit
  a_r8_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_i) && !$past(set_i)) |-> !q);
endmodule

// File: rtl/sbpt_badpar_hold.sv
module sbpt_badpar_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic up_bad_par,
  input  logic txn_end,
  output logic force_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          force_o <= 1'b0;
    else if (txn_end)    force_o <= 1'b0;
    else if (up_bad_par) force_o <= 1'b1;
  end

  // R7: forcing never runs past the end of its transaction
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(txn_end) |-> !force_o);
endmodule

// File: rtl/sbus_parity_tracker.sv
module sbus_parity_tracker
  import sbpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_data_perr,
  input  logic              perr_seen,
  input  logic              cyc_write,
  input  logic              is_master,
  input  logic              evt_addr_perr,
  input  logic              up_bad_par,
  input  logic              txn_end,
  input  logic              en_serr,
  input  logic              en_perr_resp,
  input  logic              en_bctrl_serr,
  input  logic              w1c_strobe,
  input  logic [STAT_W-1:0] w1c_mask,
  output logic [STAT_W-1:0] status,
  output logic              serr_pulse,
  output logic              no_claim,
  output logic              force_bad_par
);
  stat_set_t         set_s;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic              serr_req;

  sbpt_event_qual u_qual (
    .evt_data_perr (evt_data_perr),
    .perr_seen     (perr_seen),
    .cyc_write     (cyc_write),
    .is_master     (is_master),
    .evt_addr_perr (evt_addr_perr),
    .en_serr       (en_serr),
    .en_perr_resp  (en_perr_resp),
    .en_bctrl_serr (en_bctrl_serr),
    .set_o         (set_s),
    .serr_req      (serr_req)
  );

  assign set_vec = set_s;
  assign clr_vec = w1c_mask & {STAT_W{w1c_strobe}};

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    sbpt_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q     (status[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_pulse <= 1'b0;
    else        serr_pulse <= serr_req;
  end

  // R6: an address parity error is never claimed
  assign no_claim = evt_addr_perr;

  sbpt_badpar_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_bad_par (up_bad_par),
    .txn_end    (txn_end),
    .force_o    (force_bad_par)
  );

  // R5: every SERR pulse is backed by a status bit recorded on the same edge
  a_r5_serr_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> (status[ST_SSE] | status[ST_MDPE]));
endmodule

// File: tb/test_sbus_parity_tracker.sv
module test_sbus_parity_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_data_perr, perr_seen, cyc_write, is_master, evt_addr_perr;
  logic up_bad_par, txn_end, en_serr, en_perr_resp, en_bctrl_serr;
  logic w1c_strobe;
  logic [2:0] w1c_mask;
  logic [2:0] status;
  logic serr_pulse, no_claim, force_bad_par;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [2:0] exp_stat;
  logic       exp_serr, exp_force;

  always #2.5 clk = ~clk;

  sbus_parity_tracker i_sbus_parity_tracker (.*);

  function automatic logic [2:0] f_set();
    logic [2:0] s;
    s[1] = evt_data_perr | evt_addr_perr | (perr_seen & cyc_write & is_master);
    s[2] = is_master & en_perr_resp &
           ((perr_seen & cyc_write) | (evt_data_perr & ~cyc_write));
    s[0] = evt_addr_perr & en_serr & en_perr_resp & en_bctrl_serr;
    return s;
  endfunction

  function automatic logic [2:0] f_next_stat(logic [2:0] cur, logic [2:0] s);
    logic [2:0] c;
    c = w1c_strobe ? w1c_mask : 3'b000;
    return s | (cur & ~c);
  endfunction

  function automatic logic f_next_force(logic cur);
    if (txn_end) return 1'b0;
    if (up_bad_par) return 1'b1;
    return cur;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_data_perr = 0; perr_seen = 0; cyc_write = 0; is_master = 0;
    evt_addr_perr = 0; up_bad_par = 0; txn_end = 0;
    w1c_strobe = 0; w1c_mask = 3'b000;
  endtask

  // inputs are already driven (after a negedge); advance one cycle and check
  task automatic step();
    logic [2:0] s;
    #1;
    check("R6 no_claim", {7'd0, no_claim}, {7'd0, evt_addr_perr});
    s = f_set();
    exp_serr  = s[2] | s[0];
    exp_stat  = f_next_stat(exp_stat, s);
    exp_force = f_next_force(exp_force);
    @(negedge clk);
    check("R2/R3/R4/R8/R9 status", {5'd0, status}, {5'd0, exp_stat});
    check("R5 serr_pulse", {7'd0, serr_pulse}, {7'd0, exp_serr});
    check("R7 force_bad_par", {7'd0, force_bad_par}, {7'd0, exp_force});
  endtask

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    en_serr = 1; en_perr_resp = 1; en_bctrl_serr = 1;
    exp_stat = 3'b000; exp_serr = 0; exp_force = 0;
    repeat (3) @(negedge clk);
    check("R1 reset status", {5'd0, status}, 8'd0);
    check("R1 reset serr", {7'd0, serr_pulse}, 8'd0);
    check("R1 reset force", {7'd0, force_bad_par}, 8'd0);
    rst_n = 1;
    @(negedge clk);

    // R4: each enable low on its own blocks signalled-system-error
    for (int k = 0; k < 3; k++) begin
      idle_inputs();
      en_serr = (k != 0); en_perr_resp = (k != 1); en_bctrl_serr = (k != 2);
      evt_addr_perr = 1;
      step();
      check("R4 blocked sse bit", {7'd0, status[0]}, 8'd0);
    end
    en_serr = 1; en_perr_resp = 1; en_bctrl_serr = 1;
    idle_inputs(); evt_addr_perr = 1; step();
    check("R4 all enables sse", {7'd0, status[0]}, 8'd1);
    idle_inputs(); step();
    check("R5 pulse one cycle", {7'd0, serr_pulse}, 8'd0);

    // R3: PERR# on a read, data error on a write: no master data error
    idle_inputs(); w1c_strobe = 1; w1c_mask = 3'b111; step();
    idle_inputs(); is_master = 1; perr_seen = 1; cyc_write = 0; step();
    check("R3 perr on read", {7'd0, status[2]}, 8'd0);
    idle_inputs(); is_master = 1; evt_data_perr = 1; cyc_write = 1; step();
    check("R3 data perr on write", {7'd0, status[2]}, 8'd0);
    idle_inputs(); is_master = 0; perr_seen = 1; cyc_write = 1; step();
    check("R3 not master", {7'd0, status[2]}, 8'd0);
    idle_inputs(); is_master = 1; perr_seen = 1; cyc_write = 1; step();
    check("R3 master write perr", {7'd0, status[2]}, 8'd1);

    // R8: clear coinciding with a new set keeps the bit
    idle_inputs(); evt_data_perr = 1; w1c_strobe = 1; w1c_mask = 3'b010; step();
    check("R8 set beats clear", {7'd0, status[1]}, 8'd1);
    idle_inputs(); w1c_strobe = 1; w1c_mask = 3'b010; step();
    check("R8 clear only masked", {5'd0, status}, {5'd0, exp_stat});

    // R7: end and bad parity together leave forcing off
    idle_inputs(); up_bad_par = 1; step();
    check("R7 force on", {7'd0, force_bad_par}, 8'd1);
    idle_inputs(); up_bad_par = 1; txn_end = 1; step();
    check("R7 end wins", {7'd0, force_bad_par}, 8'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      evt_data_perr = ($urandom_range(7) == 0);
      perr_seen     = ($urandom_range(7) == 0);
      cyc_write     = $urandom_range(1);
      is_master     = $urandom_range(1);
      evt_addr_perr = ($urandom_range(9) == 0);
      up_bad_par    = ($urandom_range(9) == 0);
      txn_end       = ($urandom_range(5) == 0);
      en_serr       = ($urandom_range(3) != 0);
      en_perr_resp  = ($urandom_range(3) != 0);
      en_bctrl_serr = ($urandom_range(3) != 0);
      w1c_strobe    = ($urandom_range(4) == 0);
      w1c_mask      = 3'($urandom_range(7));
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule